// File: doc/BRIEF.md
# Paired-Lane Structure Load Unit

This unit carries out the load of a single two-element structure into one lane of a pair of 128-bit vector registers. The caller supplies the current contents of both destination registers, an element-size code, a lane index, a 64-bit base address and a post-index selection with an optional offset value. The unit issues one memory read covering two adjacent elements and splits the returned data into those two elements. It inserts each element into the chosen lane of its own register and leaves every other bit as it was. It also returns the updated base address.

The unit takes one operation at a time. A `start` pulse in the idle state captures every operand. The unit then raises a read request, holds it until the memory accepts it, and waits for the response. It reports the result with a one-cycle `done` pulse. A lane index that does not fit the element size skips the memory access entirely and finishes at once with an illegal flag.

Top module: `lane_pair_load`

## Requirements
- R1: Size codes 0/1/2/3 select 8/16/32/64-bit elements, with legal lanes 0–15, 0–7, 0–3 and 0–1 respectively. An illegal lane gives `done` and `illegal` high in the cycle after `start` and issues no request. In that case `vout_a`/`vout_b` equal `vin_a`/`vin_b` and `addr_out` equals `base_addr`.
- R2: For a legal lane, `req_valid` rises in the cycle after `start` with `req_addr` equal to the base address and `req_bytes` equal to twice the element size in bytes (2, 4, 8 or 16). All three hold steady until a cycle with `req_ready` high.
- R3: The first element is bits [E-1:0] of `rsp_data` (little-endian, lowest address first). It is written to bits [lane×E +: E] of `vout_a`, where E is the element width.
- R4: The second element is bits [2E-1:E] of `rsp_data`. It is written to the same lane position of `vout_b`.
- R5: Every bit of both registers outside the selected lane keeps its value from `vin_a`/`vin_b`.
- R6: Post-index codes 0 and 3 mean no update: `addr_out` equals `base_addr`.
- R7: Post-index code 1 (immediate) gives `addr_out` = `base_addr` + 2, 4, 8 or 16 for 8-, 16-, 32- or 64-bit elements.
- R8: Post-index code 2 (register) gives `addr_out` = `base_addr` + `offs_val`. When `offs_is_zr` is high the immediate step of R7 is used instead.
- R9: `done` is a single-cycle pulse in the cycle after the cycle in which `rsp_valid` is seen while waiting. `vout_a`, `vout_b` and `addr_out` hold their values until the next `done`.
- R10: `start` is ignored while `busy` is high and does not alter the operation in flight. A synchronous active-high `rst` clears `done`, `busy` and `req_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| size | input | 2 | Element-size code |
| lane | input | 4 | Lane index |
| base_addr | input | 64 | Base address |
| post_mode | input | 2 | Post-index selection |
| offs_is_zr | input | 1 | Offset register field names the zero register |
| offs_val | input | 64 | Offset register value |
| vin_a | input | 128 | Current first destination register |
| vin_b | input | 128 | Current second destination register |
| busy | output | 1 | Operation in flight |
| req_valid | output | 1 | Memory read request valid |
| req_ready | input | 1 | Memory accepts request |
| req_addr | output | 64 | Read address |
| req_bytes | output | 5 | Read byte count |
| rsp_valid | input | 1 | Read data valid |
| rsp_data | input | 128 | Read data, little-endian |
| done | output | 1 | Result pulse |
| illegal | output | 1 | Illegal lane, valid with done |
| vout_a | output | 128 | Updated first register |
| vout_b | output | 128 | Updated second register |
| addr_out | output | 64 | Post-indexed base address |

## Verification
The bench builds the unit with its default widths: 128-bit registers, 64-bit elements at most and 64-bit addresses. At these widths all four size codes times all sixteen lane indices come to only 64 operations, so it sweeps every pair. That covers every legal lane merge, including the topmost lane of each size, and every illegal index. Post-index modes, the zero-register case, request stalls and response delays rotate across the sweep. A `start` pulse is injected while busy during stalls, and a reset is applied mid-request at the end.

// File: rtl/lpl_pkg.sv
package lpl_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } lpl_state_e;

  localparam logic [1:0] PI_IMM = 2'd1;
  localparam logic [1:0] PI_REG = 2'd2;

  function automatic logic [7:0] elem_bits(input logic [1:0] sz);
    return 8'd8 << sz;
  endfunction

  function automatic logic [4:0] struct_bytes(input logic [1:0] sz);
    return 5'd2 << sz;
  endfunction
endpackage

// File: rtl/lpl_decode.sv
module lpl_decode #(
  parameter int VEC_W = 128,
  localparam int IDX_W = $clog2(VEC_W / 8),
  localparam int SH_W  = $clog2(VEC_W)
) (
  input  logic [1:0]       size,
  input  logic [IDX_W-1:0] lane,
  output logic             lane_ok,
  output logic [7:0]       ebits,
  output logic [SH_W-1:0]  shift
);
  localparam int LANES8 = VEC_W / 8;

  logic [IDX_W:0] lane_cnt;

  always_comb begin
    lane_cnt = (IDX_W + 1)'(LANES8) >> size;
    lane_ok  = {1'b0, lane} < lane_cnt;
    ebits    = lpl_pkg::elem_bits(size);
    shift    = SH_W'(lane) << (3 + size);
  end
endmodule

// File: rtl/lpl_lane_merge.sv
module lpl_lane_merge #(
  parameter int VEC_W  = 128,
  parameter int EW_MAX = 64,
  localparam int SH_W  = $clog2(VEC_W)
) (
  input  logic [VEC_W-1:0]  old_vec,
  input  logic [EW_MAX-1:0] elem,
  input  logic [7:0]        ebits,
  input  logic [SH_W-1:0]   shift,
  output logic [VEC_W-1:0]  new_vec
);
  logic [EW_MAX-1:0] emask;
  logic [VEC_W-1:0]  wide_mask;
  logic [VEC_W-1:0]  wide_elem;

  always_comb begin
    emask     = {EW_MAX{1'b1}} >> (8'(EW_MAX) - ebits);
    wide_mask = VEC_W'(emask) << shift;
    wide_elem = VEC_W'(elem) << shift;
    new_vec   = (old_vec & ~wide_mask) | (wide_elem & wide_mask);
  end
endmodule

// File: rtl/lpl_addr_step.sv
module lpl_addr_step #(
  parameter int ADDR_W = 64
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [1:0]        size,
  input  logic [1:0]        mode,
  input  logic              offs_is_zr,
  input  logic [ADDR_W-1:0] offs_val,
  output logic              use_reg,
  output logic [ADDR_W-1:0] next_addr
);
  logic [ADDR_W-1:0] step;

  always_comb begin
    use_reg = (mode == lpl_pkg::PI_REG) && !offs_is_zr;
    if (use_reg)
      step = offs_val;
    else if (mode == lpl_pkg::PI_IMM || mode == lpl_pkg::PI_REG)
      step = ADDR_W'(lpl_pkg::struct_bytes(size));
    else
      step = '0;
    next_addr = base + step;
  end
endmodule

// File: rtl/lane_pair_load.sv
module lane_pair_load #(
  parameter int VEC_W  = 128,
  parameter int EW_MAX = 64,
  parameter int ADDR_W = 64,
  localparam int IDX_W = $clog2(VEC_W / 8),
  localparam int SH_W  = $clog2(VEC_W),
  localparam int RSP_W = 2 * EW_MAX
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [1:0]        size,
  input  logic [IDX_W-1:0]  lane,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [1:0]        post_mode,
  input  logic              offs_is_zr,
  input  logic [ADDR_W-1:0] offs_val,
  input  logic [VEC_W-1:0]  vin_a,
  input  logic [VEC_W-1:0]  vin_b,
  output logic              busy,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [ADDR_W-1:0] req_addr,
  output logic [4:0]        req_bytes,
  input  logic              rsp_valid,
  input  logic [RSP_W-1:0]  rsp_data,
  output logic              done,
  output logic              illegal,
  output logic [VEC_W-1:0]  vout_a,
  output logic [VEC_W-1:0]  vout_b,
  output logic [ADDR_W-1:0] addr_out
);
  import lpl_pkg::*;

  lpl_state_e st;

  logic [1:0]        cap_size;
  logic [IDX_W-1:0]  cap_lane;
  logic [ADDR_W-1:0] cap_base;
  logic [1:0]        cap_mode;
  logic              cap_zr;
  logic [ADDR_W-1:0] cap_offs;
  logic [VEC_W-1:0]  cap_v [2];

  // named events
  logic start_fire, req_fire, rsp_fire;
  assign start_fire = start && (st == ST_IDLE);
  assign req_fire   = (st == ST_REQ) && req_ready;
  assign rsp_fire   = (st == ST_WAIT) && rsp_valid;

  // decode operates on live inputs while idle, on captured values after
  logic [1:0]       dec_size;
  logic [IDX_W-1:0] dec_lane;
  logic             lane_ok;
  logic [7:0]       ebits;
  logic [SH_W-1:0]  shift;

  assign dec_size = (st == ST_IDLE) ? size : cap_size;
  assign dec_lane = (st == ST_IDLE) ? lane : cap_lane;

  lpl_decode #(.VEC_W(VEC_W)) u_dec (
    .size(dec_size), .lane(dec_lane),
    .lane_ok(lane_ok), .ebits(ebits), .shift(shift)
  );

  // element split: first element lowest, second right after it
  logic [RSP_W-1:0]  rsp_hi;
  logic [EW_MAX-1:0] elem [2];
  assign rsp_hi  = rsp_data >> ebits;
  assign elem[0] = rsp_data[EW_MAX-1:0];
  assign elem[1] = rsp_hi[EW_MAX-1:0];

  logic [VEC_W-1:0] merged [2];

  for (genvar g = 0; g < 2; g++) begin : g_merge
    lpl_lane_merge #(.VEC_W(VEC_W), .EW_MAX(EW_MAX)) u_merge (
      .old_vec(cap_v[g]), .elem(elem[g]), .ebits(ebits),
      .shift(shift), .new_vec(merged[g])
    );
  end

  logic              use_reg;
  logic [ADDR_W-1:0] next_addr;

  lpl_addr_step #(.ADDR_W(ADDR_W)) u_addr (
    .base(cap_base), .size(cap_size), .mode(cap_mode),
    .offs_is_zr(cap_zr), .offs_val(cap_offs),
    .use_reg(use_reg), .next_addr(next_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      done     <= 1'b0;
      illegal  <= 1'b0;
      vout_a   <= '0;
      vout_b   <= '0;
      addr_out <= '0;
      cap_size <= '0;
      cap_lane <= '0;
      cap_base <= '0;
      cap_mode <= '0;
      cap_zr   <= 1'b0;
      cap_offs <= '0;
      cap_v[0] <= '0;
      cap_v[1] <= '0;
    end else begin
      done    <= 1'b0;
      illegal <= 1'b0;
      unique case (st)
        ST_IDLE: if (start_fire) begin
          cap_size <= size;
          cap_lane <= lane;
          cap_base <= base_addr;
          cap_mode <= post_mode;
          cap_zr   <= offs_is_zr;
          cap_offs <= offs_val;
          cap_v[0] <= vin_a;
          cap_v[1] <= vin_b;
          if (lane_ok) begin
            st <= ST_REQ;
          end else begin
            done     <= 1'b1;
            illegal  <= 1'b1;
            vout_a   <= vin_a;
            vout_b   <= vin_b;
            addr_out <= base_addr;
          end
        end
        ST_REQ: if (req_fire) st <= ST_WAIT;
        ST_WAIT: if (rsp_fire) begin
          vout_a   <= merged[0];
          vout_b   <= merged[1];
          addr_out <= next_addr;
          done     <= 1'b1;
          st       <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign busy      = (st != ST_IDLE);
  assign req_valid = (st == ST_REQ);
  assign req_addr  = cap_base;
  assign req_bytes = struct_bytes(cap_size);

  logic unused_ok;
  assign unused_ok = use_reg;
endmodule

// File: rtl/lpl_checker.sv
module lpl_checker #(
  parameter int ADDR_W = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr,
  input logic [4:0]        req_bytes,
  input logic              done,
  input logic              illegal,
  input logic              start_fire,
  input logic              rsp_fire,
  input logic              lane_ok
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_bytes)); // R2
  AST_REQ_BYTES: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> ($countones(req_bytes) == 1) && (req_bytes >= 5'd2)); // R2
  AST_ILLEGAL_FAST: assert property (@(posedge clk) disable iff (rst)
    start_fire && !lane_ok |=> done && illegal && !req_valid); // R1
  AST_LEGAL_REQ: assert property (@(posedge clk) disable iff (rst)
    start_fire && lane_ok |=> req_valid && !done); // R2
  AST_DONE_AFTER_RSP: assert property (@(posedge clk) disable iff (rst)
    rsp_fire |=> done && !illegal); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R9
  AST_IDLE_AT_DONE: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy); // R10
  AST_RST_CLEAR: assert property (@(posedge clk)
    rst |=> !done && !busy && !req_valid); // R10
endmodule

bind lane_pair_load lpl_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .req_valid(req_valid),
  .req_ready(req_ready), .req_addr(req_addr), .req_bytes(req_bytes),
  .done(done), .illegal(illegal), .start_fire(start_fire),
  .rsp_fire(rsp_fire), .lane_ok(lane_ok)
);

// File: tb/tb_lane_pair_load.sv
module tb_lane_pair_load;
  logic         clk = 1'b0;
  logic         rst;
  logic         start;
  logic [1:0]   size;
  logic [3:0]   lane;
  logic [63:0]  base_addr;
  logic [1:0]   post_mode;
  logic         offs_is_zr;
  logic [63:0]  offs_val;
  logic [127:0] vin_a, vin_b;
  logic         busy, req_valid, req_ready, rsp_valid, done, illegal;
  logic [63:0]  req_addr, addr_out;
  logic [4:0]   req_bytes;
  logic [127:0] rsp_data, vout_a, vout_b;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  lane_pair_load dut (
    .clk(clk), .rst(rst), .start(start), .size(size), .lane(lane),
    .base_addr(base_addr), .post_mode(post_mode), .offs_is_zr(offs_is_zr),
    .offs_val(offs_val), .vin_a(vin_a), .vin_b(vin_b), .busy(busy),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_bytes(req_bytes), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .done(done), .illegal(illegal), .vout_a(vout_a), .vout_b(vout_b),
    .addr_out(addr_out)
  );

  task automatic chk(input bit ok, input string tag,
                     input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic run_op(input int sz, input int ln, input int md, input bit zr,
                        input int stall, input int delay);
    logic [127:0] va, vb, d, ea, eb, outm;
    logic [63:0]  base, offs, eaddr;
    int ew;
    bit legal;
    ew    = 8 << sz;
    legal = ln < (16 >> sz);
    va   = {$urandom, $urandom, $urandom, $urandom};
    vb   = {$urandom, $urandom, $urandom, $urandom};
    d    = {$urandom, $urandom, $urandom, $urandom};
    base = {$urandom, $urandom};
    offs = {$urandom, $urandom};
    ea = va; eb = vb; outm = '1;
    if (legal) begin
      for (int b = 0; b < ew; b++) begin
        ea[ln*ew + b]   = d[b];
        eb[ln*ew + b]   = d[ew + b];
        outm[ln*ew + b] = 1'b0;
      end
    end
    if (md == 1 || (md == 2 && zr)) eaddr = base + 64'(2 * (1 << sz));
    else if (md == 2)               eaddr = base + offs;
    else                            eaddr = base;

    @(negedge clk);
    start = 1; size = 2'(sz); lane = 4'(ln); base_addr = base;
    post_mode = 2'(md); offs_is_zr = zr; offs_val = offs; vin_a = va; vin_b = vb;
    @(negedge clk);
    start = 0;
    vin_a = ~va; vin_b = ~vb; base_addr = ~base; offs_val = ~offs;
    if (!legal) begin
      chk(done && illegal && !req_valid, "R1 illegal flags", {done, illegal, req_valid}, 3'b110);
      chk(vout_a == va && vout_b == vb, "R1 regs unchanged", vout_a, va);
      chk(addr_out == base, "R1 addr unchanged", addr_out, base);
      @(negedge clk);
      chk(!done && !busy, "R9 pulse ends", done, 0);
      return;
    end
    chk(req_valid && req_addr == base, "R2 request addr", req_addr, base);
    chk(req_bytes == 5'(2 << sz), "R2 request bytes", req_bytes, 2 << sz);
    for (int s = 0; s < stall; s++) begin
      if (s == 0) begin start = 1; size = 2'(3 - sz); lane = 4'(15 - ln); end
      @(negedge clk);
      start = 0;
      chk(req_valid && req_addr == base && req_bytes == 5'(2 << sz),
          "R2 R10 request held", req_addr, base);
    end
    req_ready = 1;
    @(negedge clk);
    req_ready = 0;
    chk(!req_valid && busy, "R2 request retired", {req_valid, busy}, 2'b01);
    for (int w = 0; w < delay; w++) begin
      @(negedge clk);
      chk(!done, "R9 no early done", done, 0);
    end
    rsp_valid = 1; rsp_data = d;
    @(negedge clk);
    rsp_valid = 0; rsp_data = ~d;
    chk(done && !illegal, "R9 done pulse", {done, illegal}, 2'b10);
    chk(vout_a == ea, "R3 first element", vout_a, ea);
    chk(vout_b == eb, "R4 second element", vout_b, eb);
    chk(((vout_a ^ va) & outm) == 0 && ((vout_b ^ vb) & outm) == 0,
        "R5 other bits kept", vout_a ^ va, 0);
    if (md == 1)      chk(addr_out == eaddr, "R7 immediate step", addr_out, eaddr);
    else if (md == 2) chk(addr_out == eaddr, "R8 register step", addr_out, eaddr);
    else              chk(addr_out == eaddr, "R6 no update", addr_out, eaddr);
    @(negedge clk);
    chk(!done && !busy, "R9 pulse ends", done, 0);
    chk(vout_a == ea && addr_out == eaddr, "R9 results held", vout_a, ea);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    rst = 1; start = 0; size = 0; lane = 0; base_addr = 0; post_mode = 0;
    offs_is_zr = 0; offs_val = 0; vin_a = 0; vin_b = 0;
    req_ready = 0; rsp_valid = 0; rsp_data = 0;
    repeat (3) @(negedge clk);
    chk(!done && !busy && !req_valid, "R10 reset state", {done, busy, req_valid}, 0);
    rst = 0;
    for (int sz = 0; sz < 4; sz++)
      for (int ln = 0; ln < 16; ln++)
        run_op(sz, ln, (sz + ln) % 4, ln[2], ln % 3, ln % 2);
    // register mode with and without zero register, top lanes
    run_op(3, 1, 2, 1'b0, 1, 0);
    run_op(3, 1, 2, 1'b1, 0, 1);
    run_op(0, 15, 2, 1'b0, 2, 1);
    run_op(2, 3, 1, 1'b0, 0, 0);
    // reset in the middle of a request
    @(negedge clk);
    start = 1; size = 1; lane = 2; post_mode = 0;
    @(negedge clk);
    start = 0;
    chk(req_valid, "R2 request raised", req_valid, 1);
    rst = 1;
    @(negedge clk);
    rst = 0;
    chk(!req_valid && !busy && !done, "R10 reset mid-request", {req_valid, busy, done}, 0);
    repeat (2) @(negedge clk);
    summary();
  end
endmodule